// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers a parameterised set of external interrupt sources and delivers them to a parameterised set of hart contexts. A hart context is one privilege mode on one hardware thread. Every source can reach every context. Each context owns one interrupt output line, a private enable mask and a priority threshold. Each source has a programmable priority and a trigger selection that picks edge or level. An arbiter in each context picks the best eligible source. Software in that context takes the interrupt by reading a claim word, and it hands the interrupt back by writing the same ID to the completion word.

Each source passes through a gateway. Between claim and completion the gateway holds back further requests from that source. For a source set to edge triggering, what happens to edges that arrive while the handler runs is fixed per source by a parameter mask. In queue mode they are counted, up to a small limit, and replayed one per completion. In drop mode they are discarded. Register access uses a plain synchronous port with address, write data, write enable and read enable. Read data is returned one cycle after the read.

Top module: `plic_core`

## Requirements
- R1: After reset, all priorities, trigger selections, enables, thresholds and pending bits are zero, every `irq` line is low, and a claim read returns 0.
- R2: Word addresses are as follows. Source s priority is at 0x000+s (s = 1..NUM_SRC). The trigger selection is at 0x100, where bit s = 1 means edge. The read-only pending vector is at 0x101, with bit s for source s. The context c enable mask is at 0x200+c, with bit s for source s. The context c threshold is at 0x300+2c. The context c claim/complete word is at 0x301+2c. `rdData` carries the addressed value in the cycle after `rdEn`.
- R3: A source is eligible for context c when it is pending, enabled for c, and its priority is strictly greater than the threshold of c. This means priority 0 and a priority equal to the threshold never qualify. `irq[c]` is high exactly when some source is eligible for c.
- R4: Among the eligible sources, the highest priority wins. On equal priority, the lowest source ID wins.
- R5: A claim read returns the winning ID, or 0 when there is none, and clears that source's pending bit in the same cycle. A read that coincides with `wrEn` has no effect.
- R6: Once a source is claimed, it raises no new request until its ID is written to any context's claim/complete word. Writing an ID that is not awaiting completion has no effect.
- R7: A level source becomes pending while its input is high and it is not claimed. On completion, it becomes pending again at once if its input is still high.
- R8: An edge source becomes pending on a rising input. Further edges while it is pending and unclaimed merge into the one request.
- R9: For a drop-mode edge source (QUEUE_MASK bit s-1 = 0), edges between the claim cycle and the completion, including the claim cycle itself, are discarded.
- R10: For a queue-mode edge source (QUEUE_MASK bit s-1 = 1), edges between the claim cycle and the completion, including the claim cycle itself, are counted up to QDEPTH (default 3). Each completion turns one counted edge into a new pending request.
- R11: An edge that arrives in the same cycle as that source's completion becomes a new pending request in either mode. In queue mode it leaves the count unchanged.
- R12: A source enabled in several contexts can be claimed and completed from any of them. A context with the source disabled never sees it on its `irq` line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Interrupt inputs; bit i is source i+1 |
| addr | input | 10 | Word address |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (claims at a claim address) |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| irq | output | NUM_CTX | One interrupt line per context |

## Verification
Two gateway events can land in the same cycle as a new edge: a claim, and a completion. The bench raises the source input in the same cycle that it drives the claim read or the completion write. It then judges the outcome from the later claims. An edge in the claim cycle must come back after completion in queue mode and must be lost in drop mode. An edge in the completion cycle must always return as a fresh request. For a queue-mode source the count must not change, which is checked by the number of claims that still succeed afterwards.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_TRIG, RD_PEND, RD_EN, RD_THR, RD_CLAIM
  } rdSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic             prioWr;
    logic             trigWr;
    logic             enWr;
    logic             thrWr;
    logic             claimRd;
    logic             complWr;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter bit QUEUE  = 1'b1,
  parameter int QDEPTH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcIn,
  input  logic isEdge,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic inFlight
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic prevIn;
  logic edgeSeen;
  logic queued;

  assign edgeSeen = isEdge & srcIn & ~prevIn;

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= 1'b0;
    else       prevIn <= srcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      inFlight <= 1'b0;
    end else if (claim) begin
      pending  <= 1'b0;
      inFlight <= 1'b1;
    end else if (complete) begin
      inFlight <= 1'b0;
      pending  <= isEdge ? (edgeSeen | queued) : srcIn;
    end else if (!inFlight && !pending) begin
      pending  <= isEdge ? edgeSeen : srcIn;
    end
  end

  generate
    if (QUEUE) begin : g_queue
      logic [CNT_W-1:0] cnt;
      logic bump;
      // edges in the claim cycle or while the handler runs
      assign bump = edgeSeen & (claim | (inFlight & ~complete));
      always_ff @(posedge clk) begin
        if (!rstN)
          cnt <= '0;
        else if (bump && cnt != CNT_W'(QDEPTH))
          cnt <= cnt + 1'b1;
        else if (complete && !edgeSeen && cnt != '0)
          cnt <= cnt - 1'b1;
      end
      assign queued = (cnt != '0);
    end else begin : g_drop
      assign queued = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC:0]             pendVec,
  input  logic [NUM_SRC:0]             enVec,
  input  logic [NUM_SRC:0][PRIO_W-1:0] prioArr,
  input  logic [PRIO_W-1:0]            thr,
  output logic [ID_W-1:0]              winId,
  output logic                         hit
);
  logic [PRIO_W-1:0] best;

  // Strict compare: threshold-equal masked, first (lowest) ID kept on ties.
  always_comb begin
    best  = thr;
    winId = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pendVec[s] && enVec[s] && prioArr[s] > best) begin
        best  = prioArr[s];
        winId = ID_W'(s);
      end
    end
  end

  assign hit = (winId != '0);
endmodule

// File: rtl/plic_ctrl.sv
module plic_ctrl
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strobe
);
  logic [1:0]       region;
  logic [IDX_W-1:0] low;
  logic [IDX_W-2:0] ctxLow;
  logic             rdOk;

  assign region = addr[ADDR_W-1 -: 2];
  assign low    = addr[IDX_W-1:0];
  assign ctxLow = addr[IDX_W-1:1];
  assign rdOk   = rdEn & ~wrEn;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    case (region)
      2'd0: begin
        if (32'(low) >= 1 && 32'(low) <= NUM_SRC) begin
          strobe.idx    = low;
          strobe.prioWr = wrEn;
          if (rdOk) strobe.rdSel = RD_PRIO;
        end
      end
      2'd1: begin
        if (low == 8'd0) begin
          strobe.trigWr = wrEn;
          if (rdOk) strobe.rdSel = RD_TRIG;
        end else if (low == 8'd1) begin
          if (rdOk) strobe.rdSel = RD_PEND;
        end
      end
      2'd2: begin
        if (32'(low) < NUM_CTX) begin
          strobe.idx  = low;
          strobe.enWr = wrEn;
          if (rdOk) strobe.rdSel = RD_EN;
        end
      end
      default: begin
        if (32'(ctxLow) < NUM_CTX) begin
          strobe.idx = IDX_W'(ctxLow);
          if (!low[0]) begin
            strobe.thrWr = wrEn;
            if (rdOk) strobe.rdSel = RD_THR;
          end else begin
            strobe.complWr = wrEn;
            strobe.claimRd = rdOk;
            if (rdOk) strobe.rdSel = RD_CLAIM;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/plic_datapath.sv
module plic_datapath
  import plic_pkg::*;
#(
  parameter int          NUM_SRC    = 8,
  parameter int          NUM_CTX    = 2,
  parameter int          PRIO_W     = 3,
  parameter int          QDEPTH     = 3,
  parameter int unsigned QUEUE_MASK = 32'h0F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [DATA_W-1:0]  wrData,
  input  strobe_t            strobe,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CTX-1:0] irq,
  output logic [NUM_SRC:0]   pendVec,
  output logic [NUM_SRC:0]   inFlight,
  output logic [NUM_SRC:0]   claimVec,
  output logic [NUM_SRC:0]   complVec
);
  localparam int SRC_W = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  logic [NUM_SRC:0][PRIO_W-1:0]  prio;
  logic [NUM_SRC:0]              trigEdge;
  logic [NUM_CTX-1:0][NUM_SRC:0] enReg;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr;
  logic [NUM_CTX-1:0][SRC_W-1:0] winId;
  logic [SRC_W-1:0]              srcSel;
  logic [CTX_W-1:0]              ctxSel;
  logic [SRC_W-1:0]              claimId;

  assign srcSel  = SRC_W'(strobe.idx);
  assign ctxSel  = CTX_W'(strobe.idx);
  assign claimId = winId[ctxSel];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prio     <= '0;
      trigEdge <= '0;
      enReg    <= '0;
      thr      <= '0;
    end else begin
      if (strobe.prioWr) prio[srcSel] <= wrData[PRIO_W-1:0];
      if (strobe.trigWr) trigEdge <= {wrData[NUM_SRC:1], 1'b0};
      if (strobe.enWr)   enReg[ctxSel] <= {wrData[NUM_SRC:1], 1'b0};
      if (strobe.thrWr)  thr[ctxSel] <= wrData[PRIO_W-1:0];
    end
  end

  // Gateways, one per source; ID 0 is never pending
  assign pendVec[0]  = 1'b0;
  assign inFlight[0] = 1'b0;
  assign claimVec[0] = 1'b0;
  assign complVec[0] = 1'b0;

  generate
    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
      assign claimVec[s] = strobe.claimRd && (claimId == SRC_W'(s));
      assign complVec[s] = strobe.complWr && (wrData == DATA_W'(s)) && inFlight[s];
      plic_gateway #(
        .QUEUE (QUEUE_MASK[s-1]),
        .QDEPTH(QDEPTH)
      ) u_gw (
        .clk     (clk),
        .rstN    (rstN),
        .srcIn   (srcIn[s-1]),
        .isEdge  (trigEdge[s]),
        .claim   (claimVec[s]),
        .complete(complVec[s]),
        .pending (pendVec[s]),
        .inFlight(inFlight[s])
      );
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      plic_arbiter #(
        .NUM_SRC(NUM_SRC),
        .PRIO_W (PRIO_W),
        .ID_W   (SRC_W)
      ) u_arb (
        .pendVec(pendVec),
        .enVec  (enReg[c]),
        .prioArr(prio),
        .thr    (thr[c]),
        .winId  (winId[c]),
        .hit    (irq[c])
      );
    end
  endgenerate

  // Registered read mux
  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else begin
      case (strobe.rdSel)
        RD_PRIO:  rdData <= DATA_W'(prio[srcSel]);
        RD_TRIG:  rdData <= DATA_W'(trigEdge);
        RD_PEND:  rdData <= DATA_W'(pendVec);
        RD_EN:    rdData <= DATA_W'(enReg[ctxSel]);
        RD_THR:   rdData <= DATA_W'(thr[ctxSel]);
        RD_CLAIM: rdData <= DATA_W'(claimId);
        default:  rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int          NUM_SRC    = 8,
  parameter int          NUM_CTX    = 2,
  parameter int          PRIO_W     = 3,
  parameter int          QDEPTH     = 3,
  parameter int unsigned QUEUE_MASK = 32'h0F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrEn,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CTX-1:0] irq
);
  strobe_t            strobe;
  logic [NUM_SRC:0]   pendVec;
  logic [NUM_SRC:0]   inFlight;
  logic [NUM_SRC:0]   claimVec;
  logic [NUM_SRC:0]   complVec;

  plic_ctrl #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX)
  ) u_ctrl (
    .addr  (addr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .strobe(strobe)
  );

  plic_datapath #(
    .NUM_SRC   (NUM_SRC),
    .NUM_CTX   (NUM_CTX),
    .PRIO_W    (PRIO_W),
    .QDEPTH    (QDEPTH),
    .QUEUE_MASK(QUEUE_MASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData),
    .irq     (irq),
    .pendVec (pendVec),
    .inFlight(inFlight),
    .claimVec(claimVec),
    .complVec(complVec)
  );
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [9:0]         addr,
  input logic               wrEn,
  input logic               rdEn,
  input logic [31:0]        rdData,
  input logic [NUM_CTX-1:0] irq,
  input logic [NUM_SRC:0]   pendVec,
  input logic [NUM_SRC:0]   inFlight,
  input logic [NUM_SRC:0]   claimVec,
  input logic [NUM_SRC:0]   complVec
);
  localparam logic [9:0] CLAIM0 = 10'h301;

  // R5
  claim_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(claimVec));

  // R5
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|claimVec) |=> ((pendVec & $past(claimVec)) == '0));

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(inFlight & ~complVec)) |=> ((pendVec & $past(inFlight & ~complVec)) == '0));

  // R3
  idle_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == CLAIM0 && !irq[0]) |=> (rdData == '0));

  // R2
  claim_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == CLAIM0) |=> (rdData <= 32'(NUM_SRC)));
endmodule

bind plic_core plic_core_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_CTX(NUM_CTX)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .irq     (irq),
  .pendVec (pendVec),
  .inFlight(inFlight),
  .claimVec(claimVec),
  .complVec(complVec)
);

// File: tb/plic_core_bench.sv
module plic_core_bench;
  localparam int NS = 8;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcIn = '0;
  logic [9:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;
  logic [NC-1:0] irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plic_core u_plic_core (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; srcIn = '0; wrEn = 1'b0; rdEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = 10'(a); wrData = 32'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 10'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic claim(input int c, output logic [31:0] id);
    rd(12'h301 + 2 * c, id);
  endtask

  task automatic complete(input int c, input int id);
    wr(12'h301 + 2 * c, id);
  endtask

  task automatic pulse(input int s);
    srcIn[s-1] = 1'b1;
    @(negedge clk);
    srcIn[s-1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    doReset();
    chk("R1 irq after reset", 32'(irq), 0);
    rd(12'h101, v); chk("R1 pending after reset", v, 0);
    rd(12'h003, v); chk("R1 priority after reset", v, 0);
    claim(0, v);    chk("R1 claim after reset", v, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    doReset();
    wr(3, 2); wr(5, 5); wr(12'h200, 32'h28);
    srcIn[2] = 1'b1; srcIn[4] = 1'b1;
    @(negedge clk);
    chk("R3 irq0 raised", 32'(irq[0]), 1);
    chk("R12 irq1 without enable", 32'(irq[1]), 0);
    rd(5, v);       chk("R2 priority readback", v, 5);
    rd(12'h101, v); chk("R2 pending vector", v, 32'h28);
    claim(0, v);    chk("R4 highest priority first", v, 5);
    claim(0, v);    chk("R4 next priority", v, 3);
    rd(12'h101, v); chk("R5 claims cleared pending", v, 0);
    chk("R6 no request while claimed", 32'(irq[0]), 0);
    complete(0, 5);
    claim(0, v);    chk("R7 level re-pends after completion", v, 5);
    srcIn[4] = 1'b0;
    complete(0, 5);
    claim(0, v);    chk("R7 low level stays idle", v, 0);
    wr(12'h201, 32'h08);
    complete(1, 3);
    claim(1, v);    chk("R12 complete and claim from context 1", v, 3);
    srcIn = '0;
  endtask

  task automatic t_prio();
    logic [31:0] v;
    doReset();
    wr(2, 4); wr(6, 4); wr(7, 6); wr(12'h200, 32'hC4); wr(12'h300, 6);
    srcIn[1] = 1'b1; srcIn[5] = 1'b1; srcIn[6] = 1'b1;
    @(negedge clk);
    chk("R3 priority equal to threshold masked", 32'(irq[0]), 0);
    wr(12'h300, 5);
    rd(12'h300, v); chk("R2 threshold readback", v, 5);
    claim(0, v);    chk("R3 above threshold delivered", v, 7);
    wr(12'h300, 0);
    claim(0, v);    chk("R4 tie goes to lowest ID", v, 2);
    claim(0, v);    chk("R4 remaining tie member", v, 6);
    wr(4, 0); wr(12'h200, 32'hD4); srcIn[3] = 1'b1;
    @(negedge clk);
    claim(0, v);    chk("R3 priority zero never delivered", v, 0);
    srcIn = '0;
  endtask

  task automatic t_drop();
    logic [31:0] v;
    doReset();
    wr(12'h100, 32'h40); wr(6, 3); wr(12'h200, 32'h40);
    rd(12'h100, v); chk("R2 trigger readback", v, 32'h40);
    pulse(6); pulse(6);
    claim(0, v);    chk("R8 edge sets pending", v, 6);
    claim(0, v);    chk("R8 edges merged while pending", v, 0);
    pulse(6); pulse(6);
    complete(0, 6);
    claim(0, v);    chk("R9 drop mode discards edges", v, 0);
    pulse(6);
    claim(0, v);    chk("R8 edge accepted after completion", v, 6);
  endtask

  task automatic t_queue();
    logic [31:0] v;
    doReset();
    wr(12'h100, 32'h04); wr(2, 1); wr(12'h200, 32'h04);
    pulse(2);
    claim(0, v);    chk("R8 queue source first claim", v, 2);
    for (int i = 0; i < 5; i++) pulse(2);
    for (int i = 0; i < 3; i++) begin
      complete(0, 2);
      claim(0, v);  chk("R10 queued edge released", v, 2);
    end
    complete(0, 2);
    claim(0, v);    chk("R10 count saturates at three", v, 0);
  endtask

  task automatic t_bogus();
    logic [31:0] v;
    doReset();
    wr(4, 2); wr(12'h200, 32'h10); srcIn[3] = 1'b1;
    @(negedge clk);
    addr = 10'h301; wrData = 0; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    rd(12'h101, v); chk("R5 read with write does not claim", v, 32'h10);
    claim(0, v);    chk("R5 claim level source", v, 4);
    complete(0, 7);
    claim(0, v);    chk("R6 unclaimed ID completion ignored", v, 0);
    complete(0, 4);
    claim(0, v);    chk("R6 matching completion releases", v, 4);
    srcIn = '0;
  endtask

  task automatic t_same();
    logic [31:0] v;
    doReset();
    wr(12'h100, 32'h22); wr(1, 2); wr(5, 2); wr(12'h200, 32'h22);
    // queue source: edge in the claim cycle
    pulse(1);
    addr = 10'h301; rdEn = 1'b1; srcIn[0] = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; srcIn[0] = 1'b0; v = rdData;
    chk("R10 claim with coincident edge", v, 1);
    complete(0, 1);
    claim(0, v);    chk("R10 claim-cycle edge queued", v, 1);
    complete(0, 1);
    claim(0, v);    chk("R10 queue empty", v, 0);
    // drop source: edge in the claim cycle
    pulse(5);
    addr = 10'h301; rdEn = 1'b1; srcIn[4] = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; srcIn[4] = 1'b0; v = rdData;
    chk("R9 claim with coincident edge", v, 5);
    complete(0, 5);
    claim(0, v);    chk("R9 claim-cycle edge dropped", v, 0);
    // drop source: edge in the completion cycle
    pulse(5);
    claim(0, v);
    addr = 10'h301; wrData = 5; wrEn = 1'b1; srcIn[4] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; srcIn[4] = 1'b0;
    claim(0, v);    chk("R11 completion-cycle edge in drop mode", v, 5);
    complete(0, 5);
    claim(0, v);    chk("R11 drop source idle afterwards", v, 0);
    // queue source: completion-cycle edge with one counted edge
    pulse(1);
    claim(0, v);
    pulse(1);
    addr = 10'h301; wrData = 1; wrEn = 1'b1; srcIn[0] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; srcIn[0] = 1'b0;
    claim(0, v);    chk("R11 completion-cycle edge in queue mode", v, 1);
    complete(0, 1);
    claim(0, v);    chk("R11 queued count kept", v, 1);
    complete(0, 1);
    claim(0, v);    chk("R11 queue drained", v, 0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_prio();
    t_drop();
    t_queue();
    t_bogus();
    t_same();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule